// File: doc/BRIEF.md
# Selectable-Latency Read Output Stage

This block is the read-data output stage of a synchronous memory. Every clock edge it captures a command: read, deselect or wait. It then decides when the array data reaches the data bus and when the bus drivers switch on and off. A static latency mode picks one of two paths. In flow-through operation the array word passes combinationally to the bus in the cycle after the read is captured. In pipelined operation the word first goes through a rising-edge output register, which adds one cycle.

A second static mode sets the deselect timing. With single-cycle deselect the drivers turn off one stage earlier than a read would reach the bus. With dual-cycle deselect the turn-off travels through as many stages as read data does. An active-high output enable gates the drivers without waiting for a clock. Reads and deselects are tracked in separate pipeline stages, so a read that closely follows a deselect still drives at its normal latency. The mode inputs are meant to change only while reset is held.

Top module: `rd_out_path`

## Requirements
- R1: While reset is asserted, driveEn is 0 and dataOut is all zeros.
- R2: With pipeMode=0 (flow-through), after an edge that captures cmd=2'b01 (read), driveEn is high for the following cycle and dataOut equals arrData as presented in that same cycle. A read sampled at the second edge gives 2-1-1-1 burst timing.
- R3: With pipeMode=1 (pipelined), the arrData presented in the cycle after a read is captured is registered at the next edge. It is driven on dataOut, with driveEn high, for the whole cycle after that edge. This is one cycle more than R2 and gives 3-1-1-1 timing.
- R4: A captured cmd=2'b00 (wait) leaves the driver state unchanged and keeps the last read word on dataOut while driving.
- R5: With pipeMode=1 and dualDesel=1, a captured cmd=2'b10 (deselect) turns the drivers off after the second edge following the command, which is the same depth as read data.
- R6: With pipeMode=1 and dualDesel=0, the drivers turn off in the cycle right after the edge that captures a deselect, unless a read has reached the output stage in that cycle.
- R7: With pipeMode=0, the drivers turn off in the cycle right after the edge that captures a deselect, for either value of dualDesel.
- R8: A read that reaches its output stage always drives, even when a deselect was captured on the edge just before or just after it.
- R9: When outEn is 0, driveEn is 0 and dataOut is zero at once, with no clock edge needed. The internal driver state is untouched, so restoring outEn shows the state that pipeline flow alone would give.
- R10: The unused command code 2'b11 behaves exactly like wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pipeMode | input | 1 | Static: 1 selects the registered output path, 0 selects flow-through |
| dualDesel | input | 1 | Static: 1 selects dual-cycle deselect, 0 selects single-cycle |
| outEn | input | 1 | Asynchronous output enable, active high |
| cmd | input | 2 | Per-cycle command: 00 wait, 01 read, 10 deselect, 11 wait |
| arrData | input | DATA_W | Array read word for the access captured at the last edge |
| dataOut | output | DATA_W | Read data bus, zero when not driven |
| driveEn | output | 1 | Bus driver enable |

## Verification
In pipelined single-cycle-deselect mode, a read can reach the output stage in the same cycle that a newly captured deselect asks the drivers to turn off. The read has to win, and the drivers then have to go off one cycle later. The bench provokes this with directed read-then-deselect and read-wait-deselect runs in all four mode combinations, and also with random command streams. It judges every cycle against a reference that tracks read and deselect stages separately. A second overlap is outEn dropping in the middle of a cycle while a read is in flight. That is judged by showing the driver state after outEn comes back.

// File: rtl/rd_out_pkg.sv
package rd_out_pkg;

  typedef enum logic [1:0] {
    CMD_WAIT  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_DESEL = 2'b10,
    CMD_SPARE = 2'b11
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOut;  // capture array word into output register
    logic bypass;   // flow-through: present array word directly
    logic drive;    // pipeline-derived driver state for this cycle
  } strobe_t;

endpackage

// File: rtl/rd_out_ctrl.sv
module rd_out_ctrl
  import rd_out_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pipeMode,
  input  logic       dualDesel,
  input  logic [1:0] cmd,
  output strobe_t    strobe
);

  localparam int STAGES = 2;

  logic [1:0] stageCmd [STAGES];
  logic       onPrev;
  logic       onNow;
  logic [STAGES-1:0] isRd;
  logic [STAGES-1:0] isDs;

  // command stages: stage 0 is captured at the last edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageCmd[i] <= CMD_DESEL;
    end else begin
      stageCmd[0] <= cmd;
      for (int i = 1; i < STAGES; i++) stageCmd[i] <= stageCmd[i-1];
    end
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_dec
      assign isRd[g] = (stageCmd[g] == CMD_READ);
      assign isDs[g] = (stageCmd[g] == CMD_DESEL);
    end
  endgenerate

  // driver state: read at output stage wins, then deselect, else hold
  always_comb begin
    onNow = onPrev;
    if (pipeMode) begin
      if (isRd[1])                   onNow = 1'b1;
      else if (!dualDesel && isDs[0]) onNow = 1'b0;
      else if (isDs[1])              onNow = 1'b0;
    end else begin
      if (isRd[0])      onNow = 1'b1;
      else if (isDs[0]) onNow = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) onPrev <= 1'b0;
    else       onPrev <= onNow;
  end

  always_comb begin
    strobe.loadOut = isRd[0];
    strobe.bypass  = !pipeMode && isRd[0];
    strobe.drive   = onNow;
  end

endmodule

// File: rtl/rd_out_dp.sv
module rd_out_dp
  import rd_out_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              outEn,
  input  logic [DATA_W-1:0] arrData,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn
);

  logic [DATA_W-1:0] outReg;
  logic [DATA_W-1:0] selData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outReg <= '0;
    else if (strobe.loadOut) outReg <= arrData;
  end

  assign selData = strobe.bypass ? arrData : outReg;
  assign driveEn = outEn && strobe.drive;
  assign dataOut = driveEn ? selData : '0;

endmodule

// File: rtl/rd_out_path.sv
module rd_out_path
  import rd_out_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              dualDesel,
  input  logic              outEn,
  input  logic [1:0]        cmd,
  input  logic [DATA_W-1:0] arrData,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn
);

  strobe_t strobe;

  rd_out_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pipeMode  (pipeMode),
    .dualDesel (dualDesel),
    .cmd       (cmd),
    .strobe    (strobe)
  );

  rd_out_dp #(.DATA_W(DATA_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .outEn   (outEn),
    .arrData (arrData),
    .dataOut (dataOut),
    .driveEn (driveEn)
  );

endmodule

// File: rtl/rd_out_path_chk.sv
module rd_out_path_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              pipeMode,
  input logic              dualDesel,
  input logic              outEn,
  input logic [1:0]        cmd,
  input logic [DATA_W-1:0] arrData,
  input logic [DATA_W-1:0] dataOut,
  input logic              driveEn
);

  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!driveEn && dataOut == '0));

  a_r9_oe_gates: assert property (@(posedge clk)
    !outEn |-> (!driveEn && dataOut == '0));

  a_r2_flow_same_cycle: assert property (@(posedge clk) disable iff (!rstN || upCnt < 2'd1)
    (!pipeMode && outEn && $past(cmd) == 2'b01) |-> (driveEn && dataOut == arrData));

  a_r3_pipe_one_more: assert property (@(posedge clk) disable iff (!rstN || upCnt < 2'd2)
    (pipeMode && outEn && $past(cmd, 2) == 2'b01) |-> (driveEn && dataOut == $past(arrData)));

  a_r5_dual_off: assert property (@(posedge clk) disable iff (!rstN || upCnt < 2'd2)
    (pipeMode && dualDesel && $past(cmd, 2) == 2'b10) |-> !driveEn);

  a_r6_single_off: assert property (@(posedge clk) disable iff (!rstN || upCnt < 2'd2)
    (pipeMode && !dualDesel && $past(cmd) == 2'b10 && $past(cmd, 2) != 2'b01) |-> !driveEn);

  a_r7_flow_off: assert property (@(posedge clk) disable iff (!rstN || upCnt < 2'd1)
    (!pipeMode && $past(cmd) == 2'b10) |-> !driveEn);

endmodule

bind rd_out_path rd_out_path_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pipeMode  (pipeMode),
  .dualDesel (dualDesel),
  .outEn     (outEn),
  .cmd       (cmd),
  .arrData   (arrData),
  .dataOut   (dataOut),
  .driveEn   (driveEn)
);

// File: tb/test_rd_out_path.sv
`timescale 1ns/1ps
module test_rd_out_path;

  localparam int DATA_W = 36;
  localparam logic [1:0] WT = 2'b00, RD = 2'b01, DS = 2'b10, SP = 2'b11;

  logic              clk = 1'b0;
  logic              rstN;
  logic              pipeMode;
  logic              dualDesel;
  logic              outEn;
  logic [1:0]        cmd;
  logic [DATA_W-1:0] arrData;
  logic [DATA_W-1:0] dataOut;
  logic              driveEn;

  int errors = 0;
  int checks = 0;

  // reference state
  logic [1:0]        c1, c2, c3, drvCmd;
  logic              onPrevM, onNowM;
  logic [DATA_W-1:0] outRegM, arrCur;

  always #2.5 clk = ~clk;

  rd_out_path #(.DATA_W(DATA_W)) i_rd_out_path (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .dualDesel(dualDesel),
    .outEn(outEn), .cmd(cmd), .arrData(arrData), .dataOut(dataOut), .driveEn(driveEn)
  );

  function automatic logic calcOn(input logic pm, input logic dd, input logic [1:0] s1,
                                  input logic [1:0] s2, input logic prev);
    if (pm) begin
      if (s2 == RD)             return 1'b1;
      if (!dd && s1 == DS)      return 1'b0;
      if (s2 == DS)             return 1'b0;
      return prev;
    end
    if (s1 == RD) return 1'b1;
    if (s1 == DS) return 1'b0;
    return prev;
  endfunction

  function automatic string pickTag(input logic pm, input logic dd, input logic oe);
    if (!oe) return "R9";
    if (pm) begin
      if (c2 == RD) return (c3 == DS || c1 == DS) ? "R8" : "R3";
      if (!dd && c1 == DS) return "R6";
      if (c2 == DS) return dd ? "R5" : "R6";
      return (c2 == SP) ? "R10" : "R4";
    end
    if (c1 == RD) return (c2 == DS) ? "R8" : "R2";
    if (c1 == DS) return "R7";
    return (c1 == SP) ? "R10" : "R4";
  endfunction

  task automatic check(input string tag, input logic expDrv, input logic [DATA_W-1:0] expData);
    checks++;
    if (driveEn !== expDrv || dataOut !== expData) begin
      errors++;
      $display("FAIL %s: driveEn=%0b dataOut=%h expected driveEn=%0b dataOut=%h",
               tag, driveEn, dataOut, expDrv, expData);
    end
  endtask

  task automatic doReset(input logic pm, input logic dd);
    rstN = 1'b0; pipeMode = pm; dualDesel = dd; cmd = WT; outEn = 1'b1;
    arrData = '0; arrCur = '0; drvCmd = WT;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", 1'b0, '0);
    c1 = DS; c2 = DS; c3 = DS; onPrevM = 1'b0; onNowM = 1'b0; outRegM = '0;
    rstN = 1'b1;
  endtask

  // one clock: edge updates the reference, then drive, then judge at negedge
  task automatic cycle(input logic [1:0] nextCmd, input logic oe);
    logic expDrv;
    logic [DATA_W-1:0] selD;
    @(posedge clk);
    c3 = c2; c2 = c1;
    if (c1 == RD) outRegM = arrCur;
    c1 = drvCmd;
    onPrevM = onNowM;
    #1;
    arrCur = {$urandom, $urandom};
    arrData = arrCur;
    cmd = nextCmd; drvCmd = nextCmd;
    outEn = oe;
    onNowM = calcOn(pipeMode, dualDesel, c1, c2, onPrevM);
    @(negedge clk);
    expDrv = oe && onNowM;
    selD = (!pipeMode && c1 == RD) ? arrCur : outRegM;
    check(pickTag(pipeMode, dualDesel, oe), expDrv, expDrv ? selD : '0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int m = 0; m < 4; m++) begin
      doReset(m[1], m[0]);
      // directed: read then deselect (read at stage must win, R8/R6)
      cycle(RD, 1'b1); cycle(DS, 1'b1); cycle(WT, 1'b1); cycle(WT, 1'b1); cycle(WT, 1'b1);
      // read, wait, deselect: single vs dual deselect differ (R5, R6, R4)
      cycle(RD, 1'b1); cycle(WT, 1'b1); cycle(DS, 1'b1); cycle(WT, 1'b1); cycle(WT, 1'b1);
      // deselect immediately followed by read (R8)
      cycle(DS, 1'b1); cycle(RD, 1'b1); cycle(SP, 1'b1); cycle(SP, 1'b1); cycle(WT, 1'b1);
      // outEn dropped mid-burst then restored (R9)
      cycle(RD, 1'b1); cycle(RD, 1'b0); cycle(WT, 1'b0); cycle(WT, 1'b1); cycle(WT, 1'b1);
      // random traffic
      for (int i = 0; i < 300; i++) begin
        logic [1:0] rc;
        rc = 2'($urandom_range(0, 3));
        cycle(rc, ($urandom_range(0, 9) != 0));
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule